// File: doc/BRIEF.md
# Carry-Select Adder Built from Sum-from-Carry Cells

This block is a purely combinational 32-bit adder. It takes two operands and a carry input, and returns a 32-bit sum and a carry output. The operands are cut into equal slices of four bits.

The lowest slice is a single ripple chain fed straight from the carry input. Each higher slice runs two ripple chains side by side. One chain assumes an incoming carry of zero and the other assumes one. When the real carry arrives from the slice below, a multiplexer picks the matching sum and carry. The picked carry then steers the next slice's multiplexer. In this way the long carry path becomes a chain of multiplexers rather than a chain of full adders.

Every chain is built from one full-adder cell. The cell forms its carry as the majority of its three inputs. It then forms its sum from its own inverted carry, so no XOR gate is used. The block is meant to sit between registers owned by the surrounding datapath.

Top module: `csel_adder`

## Requirements
- R1: For every pair of operands and every carry input, {carry_out, sum_out} equals op_a + op_b + carry_in computed to 33 bits.
- R2: Each full-adder cell drives its carry output high exactly when two or more of its three inputs are high.
- R3: Each full-adder cell drives its sum as (a AND b AND cin) OR ((a OR b OR cin) AND NOT carry-out), which equals the odd parity of its three inputs.
- R4: Bits 3..0 come from a single ripple chain fed directly by carry_in. With both operands zero and carry_in 1, sum_out is 0x00000001 and carry_out is 0.
- R5: In every slice above the lowest, the result of the assume-one chain equals the result of the assume-zero chain plus one, taken over the slice width plus its carry bit.
- R6: Each upper slice outputs the assume-one result when the carry from the slice below is 1, and the assume-zero result otherwise. Its selected carry becomes the select of the next slice. For example, 0x0000000F + 0x00000001 gives 0x00000010.
- R7: A carry that enters at carry_in reaches carry_out through all eight slices. 0xFFFFFFFF + 0x00000000 with carry_in 1 gives sum_out 0x00000000 and carry_out 1.
- R8: 0x7FFFFFFF + 0x7FFFFFFF with carry_in 1 gives sum_out 0xFFFFFFFF and carry_out 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 32 | Sum bits |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
Two functions can act in the same evaluation. A slice can generate its own carry at the same moment that the multiplexer of the next slice is choosing on that carry. The critical cases are also those where the assume-one chain of the next slice overflows, so one carry must ripple through several multiplexers in a row.

The bench provokes these cases with the following vectors:
- All-ones operands combined with carry_in.
- Values that sit just below a slice boundary.
- Alternating bit patterns.
- The half-range vector from R8.

In every case the bench compares the full 33-bit result against its own wide addition. The result is sampled half a clock period after the inputs change.

// File: rtl/csel_pkg.sv
package csel_pkg;
    localparam int CSEL_DATA_W = 32;
    localparam int CSEL_GRP_W  = 4;

    // number of slices for a given operand and slice width
    function automatic int slice_count(input int data_w, input int grp_w);
        return (data_w + grp_w - 1) / grp_w;
    endfunction

    typedef struct packed {
        logic                  carry;
        logic [CSEL_GRP_W-1:0] sum;
    } slice_res_t;
endpackage

// File: rtl/sfc_full_adder.sv
module sfc_full_adder (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic maj;
    logic any_one;
    logic all_one;

    always_comb begin
        maj     = (a & b) | (a & cin) | (b & cin);
        any_one = a | b | cin;
        all_one = a & b & cin;
        cout    = maj;
        sum     = all_one | (any_one & ~maj);
    end

    always_comb begin
        // R2: carry high exactly for two or more ones
        a_r2_majority_carry: assert (cout == ($countones({a, b, cin}) >= 2))
            else $error("cell carry wrong");
        // R3: sum equals odd parity of the inputs
        a_r3_parity_sum: assert (sum == (a ^ b ^ cin))
            else $error("cell sum wrong");
    end
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        sfc_full_adder u_cell (
            .a    (a[i]),
            .b    (b[i]),
            .cin  (carry[i]),
            .sum  (sum[i]),
            .cout (carry[i+1])
        );
    end

    assign cout = carry[WIDTH];
endmodule

// File: rtl/select_slice.sv
module select_slice #(
    parameter int WIDTH  = 4,
    parameter bit LOWEST = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    if (LOWEST) begin : g_single
        // bottom slice: true carry known up front, one chain suffices
        ripple_chain #(.WIDTH(WIDTH)) u_chain (
            .a    (a),
            .b    (b),
            .cin  (cin),
            .sum  (sum),
            .cout (cout)
        );
    end else begin : g_dual
        logic [WIDTH-1:0] sum_z;
        logic [WIDTH-1:0] sum_o;
        logic             cy_z;
        logic             cy_o;

        ripple_chain #(.WIDTH(WIDTH)) u_chain_zero (
            .a    (a),
            .b    (b),
            .cin  (1'b0),
            .sum  (sum_z),
            .cout (cy_z)
        );

        ripple_chain #(.WIDTH(WIDTH)) u_chain_one (
            .a    (a),
            .b    (b),
            .cin  (1'b1),
            .sum  (sum_o),
            .cout (cy_o)
        );

        // one select steers both sum and carry
        always_comb begin
            if (cin) begin
                sum  = sum_o;
                cout = cy_o;
            end else begin
                sum  = sum_z;
                cout = cy_z;
            end
        end

        always_comb begin
            // R5: assume-one result is assume-zero result plus one
            a_r5_pair_offset: assert ({cy_o, sum_o} == ({cy_z, sum_z} + (WIDTH+1)'(1)))
                else $error("speculative chains disagree");
            // R6: output follows the chain named by the incoming carry
            a_r6_select_follows: assert ({cout, sum} == (cin ? {cy_o, sum_o} : {cy_z, sum_z}))
                else $error("slice select wrong");
        end
    end
endmodule

// File: rtl/csel_adder.sv
module csel_adder
    import csel_pkg::*;
#(
    parameter int DATA_W = CSEL_DATA_W,
    parameter int GRP_W  = CSEL_GRP_W
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    localparam int NUM_SLICE = slice_count(DATA_W, GRP_W);

    logic [NUM_SLICE:0] slice_cy;

    assign slice_cy[0] = carry_in;

    for (genvar g = 0; g < NUM_SLICE; g++) begin : g_slice
        select_slice #(
            .WIDTH  (GRP_W),
            .LOWEST (g == 0)
        ) u_slice (
            .a    (op_a[g*GRP_W +: GRP_W]),
            .b    (op_b[g*GRP_W +: GRP_W]),
            .cin  (slice_cy[g]),
            .sum  (sum_out[g*GRP_W +: GRP_W]),
            .cout (slice_cy[g+1])
        );
    end

    assign carry_out = slice_cy[NUM_SLICE];

    always_comb begin
        // R1: full result matches wide addition
        a_r1_wide_sum: assert ({carry_out, sum_out} ==
                               ({1'b0, op_a} + {1'b0, op_b} + {{DATA_W{1'b0}}, carry_in}))
            else $error("adder result wrong");
    end
endmodule

// File: tb/csel_adder_test.sv
module csel_adder_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    csel_adder uut (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // drive at rising edge, sample at the following falling edge
    task automatic apply_check(input logic [W-1:0] a, input logic [W-1:0] b,
                               input logic ci, input logic [W:0] exp_v,
                               input string req);
        @(posedge clk);
        op_a = a;
        op_b = b;
        carry_in = ci;
        @(negedge clk);
        checks++;
        if ({carry_out, sum_out} !== exp_v) begin
            errors++;
            $display("FAIL %s: a=%h b=%h ci=%0d actual=%h expected=%h",
                     req, a, b, ci, {carry_out, sum_out}, exp_v);
        end
    endtask

    function automatic logic [W:0] ref_add(input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic ci);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    endfunction

    task automatic t_idle_state();
        // R1 quiet inputs give a zero result
        apply_check('0, '0, 1'b0, 33'h0, "R1 idle");
    endtask

    task automatic t_low_slice();
        apply_check('0, '0, 1'b1, 33'h0_0000_0001, "R4");
        apply_check(32'h0000_0007, 32'h0000_0008, 1'b1, 33'h0_0000_0010, "R4");
    endtask

    task automatic t_slice_boundary();
        apply_check(32'h0000_000F, 32'h0000_0001, 1'b0, 33'h0_0000_0010, "R6");
        apply_check(32'h0000_00FF, 32'h0000_0000, 1'b1, 33'h0_0000_0100, "R6");
        apply_check(32'h0FFF_FFF0, 32'h0000_0010, 1'b0, 33'h0_1000_0000, "R6");
        // R5 upper slices with and without incoming carry
        apply_check(32'h1234_5678, 32'h1111_1111, 1'b0, 33'h0_2345_6789, "R5");
        apply_check(32'h0F0F_0F0F, 32'h0101_0101, 1'b1, 33'h0_1010_1011, "R5");
    endtask

    task automatic t_full_ripple();
        apply_check(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 33'h1_0000_0000, "R7");
        apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF, "R7");
        apply_check(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 33'h1_FFFF_FFFE, "R7");
    endtask

    task automatic t_half_range();
        apply_check(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 33'h0_FFFF_FFFF, "R8");
    endtask

    task automatic t_patterns();
        // R2 R3 cells exercised with alternating bits
        apply_check(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF, "R2");
        apply_check(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000, "R3");
        apply_check(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 33'h1_5555_5554, "R2");
        apply_check(32'h5555_5555, 32'h5555_5555, 1'b1, 33'h0_AAAA_AAAB, "R3");
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            logic         ci;
            a  = $urandom;
            b  = $urandom;
            ci = 1'($urandom);
            apply_check(a, b, ci, ref_add(a, b, ci), "R1 random");
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_idle_state();
        t_low_slice();
        t_slice_boundary();
        t_full_ripple();
        t_half_range();
        t_patterns();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule